// File: doc/BRIEF.md
# Programmable Microcoded Control Sequencer

The sequencer walks through a small microprogram kept in an internal RAM and turns it into one-cycle action strobes for the logic around it. Software fills the RAM through one narrow port before the program runs. Each word on that port is either a new write pointer or a program word. Program words go to the pointer, and the pointer then advances. A run-enable input starts execution from address 0.

There are four instruction types. An action instruction carries a sparse two-hot action code. The code is decoded into registered strobes, one per pair of code bits. A conditional jump tests one of the condition inputs, picked by a select field, and branches only when that condition is true. This allows a branch back to the same address, so a step can repeat while a status condition holds. A plain jump always branches. A wait instruction stalls until its condition comes true.

Two kinds of input can force the program counter. A device-initialisation event sends execution to a fixed entry address. Any program write made while running aborts execution back to address 0.

Top module: `useq_sequencer`

## Requirements
- R1: After reset, `pc_o` is 0 and every bit of `act_o` is 0.
- R2: While `run_en_i` is low, `pc_o` is 0 on the next cycle and no strobe fires.
- R3: A port word with `pgm_is_addr_i` high sets the write pointer to its low 10 bits. A port word with `pgm_is_addr_i` low is stored at the pointer, and the pointer then increments by one.
- R4: Instruction types sit in word bits [17:16]: 00 action, 01 conditional jump, 10 jump, 11 wait. An action instruction moves the PC to PC+1. One cycle later it sets `act_o[j]` for every action j whose two code bits are both 1 in word bits [10:0]. Action numbering takes bit pairs (lo,hi) with lo ascending, and for each lo, hi ascending from lo+1 to 10. Bit j of `act_o` is the j-th pair counted from 0: (0,1) is bit 0 and (9,10) is bit 54. An all-zero code is a no-operation.
- R5: Every strobe lasts one cycle. No strobe fires after a non-action instruction, or after a cycle overridden by an event, a write or a low run-enable.
- R6: A conditional jump selects `cond_i[word[15:10]]`. When that bit is 1 it loads the PC with word[9:0]; otherwise it goes to PC+1. A target equal to the jump's own address repeats the jump while the condition holds.
- R7: A jump instruction always loads the PC with word[9:0].
- R8: A wait instruction keeps the PC unchanged while `cond_i[word[15:10]]` is 0, and moves to PC+1 once it is 1.
- R9: With run enabled and no program write, a high `evt_init_i` forces the PC to `ENTRY_PC` (default 0x020) on the next cycle, whatever instruction is current.
- R10: A program write while `run_en_i` is high forces the PC to 0 on the next cycle. A write takes precedence over an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en_i | input | 1 | Run enable; low holds the PC at 0 |
| pgm_valid_i | input | 1 | Program port word is valid this cycle |
| pgm_is_addr_i | input | 1 | The valid word is a write pointer, not data |
| pgm_word_i | input | 18 | Program port address/data word |
| evt_init_i | input | 1 | Device-initialisation event, forces the entry address |
| cond_i | input | 64 | Condition inputs, picked by the select field |
| pc_o | output | 10 | Current program counter |
| act_o | output | 55 | Registered one-cycle action strobes |

## Verification
On every cycle the assertions check the control rules. A low run-enable or an aborting write leaves the PC at 0. An event lands on the entry address. A jump reaches its target. A stalled wait keeps the PC. A strobe can only follow an enabled action cycle.

Only the bench's scenarios can show that the program written over the port is what gets executed. The same holds for the pair-to-strobe numbering, the self-looping conditional jump and the overall PC trace. The bench shows these by comparing each cycle against a reference model driven by random conditions and events.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    OP_ACT  = 2'b00,
    OP_CJMP = 2'b01,
    OP_JMP  = 2'b10,
    OP_WAIT = 2'b11
  } useq_op_e;

  // number of distinct bit pairs in a w-bit code
  function automatic int pair_count(input int w);
    return (w * (w - 1)) / 2;
  endfunction

  // lower bit of pair number k (0-based), pairs ordered lo-major, hi-minor
  function automatic int pair_lo(input int w, input int k);
    int idx;
    idx = 0;
    for (int lo = 0; lo < w; lo++)
      for (int hi = lo + 1; hi < w; hi++) begin
        if (idx == k) return lo;
        idx++;
      end
    return 0;
  endfunction

  // upper bit of pair number k
  function automatic int pair_hi(input int w, input int k);
    int idx;
    idx = 0;
    for (int lo = 0; lo < w; lo++)
      for (int hi = lo + 1; hi < w; hi++) begin
        if (idx == k) return hi;
        idx++;
      end
    return 1;
  endfunction

endpackage

// File: rtl/useq_prog_ram.sv
module useq_prog_ram #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_is_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wptr;
  logic              data_wr;

  assign data_wr = wr_valid && !wr_is_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)                       wptr <= '0;
    else if (wr_valid && wr_is_addr)  wptr <= wr_word[ADDR_W-1:0];
    else if (data_wr)                 wptr <= wptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (data_wr) mem[wptr] <= wr_word;
  end

  assign rd_data = mem[rd_addr];

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> wptr == $past(wptr) + 1'b1);
endmodule

// File: rtl/useq_pc_unit.sv
module useq_pc_unit
  import useq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WORD_W   = 18,
  parameter int ACT_W    = 11,
  parameter int SEL_W    = 6,
  parameter int ENTRY_PC = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_en,
  input  logic                  abort,
  input  logic                  evt,
  input  logic [WORD_W-1:0]     instr,
  input  logic [(1<<SEL_W)-1:0] cond_vec,
  output logic [ADDR_W-1:0]     pc,
  output logic                  act_en,
  output logic [ACT_W-1:0]      act_code
);
  localparam logic [ADDR_W-1:0] ENTRY = ADDR_W'(ENTRY_PC);

  useq_op_e          op;
  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] tgt;
  logic              cond_hit;
  logic              exec_ok;
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] pc_nxt;

  assign op       = useq_op_e'(instr[WORD_W-1 -: 2]);
  assign sel      = instr[ADDR_W +: SEL_W];
  assign tgt      = instr[ADDR_W-1:0];
  assign cond_hit = cond_vec[sel];
  assign exec_ok  = run_en && !abort && !evt;
  assign pc_inc   = pc + 1'b1;
  assign act_en   = exec_ok && (op == OP_ACT);
  assign act_code = instr[ACT_W-1:0];

  always_comb begin
    if (!run_en || abort) pc_nxt = '0;
    else if (evt)         pc_nxt = ENTRY;
    else begin
      unique case (op)
        OP_ACT:  pc_nxt = pc_inc;
        OP_CJMP: pc_nxt = cond_hit ? tgt : pc_inc;
        OP_JMP:  pc_nxt = tgt;
        OP_WAIT: pc_nxt = cond_hit ? pc_inc : pc;
        default: pc_nxt = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nxt;
  end

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> pc == '0);
  // R9
  evt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !abort && evt) |=> pc == ENTRY);
  // R7
  jmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ok && op == OP_JMP) |=> pc == $past(tgt));
  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ok && op == OP_WAIT && !cond_hit) |=> $stable(pc));
endmodule

// File: rtl/useq_act_dec.sv
module useq_act_dec
  import useq_pkg::*;
#(
  parameter int ACT_W = 11,
  parameter int NACT  = 55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACT_W-1:0] code,
  output logic [NACT-1:0]  strobe
);
  for (genvar k = 0; k < NACT; k++) begin : g_pair
    localparam int LO = pair_lo(ACT_W, k);
    localparam int HI = pair_hi(ACT_W, k);
    always_ff @(posedge clk) begin
      if (!rst_n) strobe[k] <= 1'b0;
      else        strobe[k] <= en && code[LO] && code[HI];
    end
  end

  // R5
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) |-> $past(en));
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WORD_W   = 18,
  parameter int ACT_W    = 11,
  parameter int SEL_W    = 6,
  parameter int ENTRY_PC = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                run_en_i,
  input  logic                                pgm_valid_i,
  input  logic                                pgm_is_addr_i,
  input  logic [WORD_W-1:0]                   pgm_word_i,
  input  logic                                evt_init_i,
  input  logic [(1<<SEL_W)-1:0]               cond_i,
  output logic [ADDR_W-1:0]                   pc_o,
  output logic [(ACT_W*(ACT_W-1))/2-1:0]      act_o
);
  localparam int NACT = pair_count(ACT_W);

  logic [WORD_W-1:0] instr;
  logic              abort;
  logic              act_en;
  logic [ACT_W-1:0]  act_code;

  assign abort = pgm_valid_i && run_en_i;

  useq_prog_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(pgm_valid_i), .wr_is_addr(pgm_is_addr_i), .wr_word(pgm_word_i),
    .rd_addr(pc_o), .rd_data(instr)
  );

  useq_pc_unit #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .ACT_W(ACT_W),
                 .SEL_W(SEL_W), .ENTRY_PC(ENTRY_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .run_en(run_en_i), .abort(abort),
    .evt(evt_init_i), .instr(instr), .cond_vec(cond_i),
    .pc(pc_o), .act_en(act_en), .act_code(act_code)
  );

  useq_act_dec #(.ACT_W(ACT_W), .NACT(NACT)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(act_en), .code(act_code), .strobe(act_o)
  );

  // R10
  write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (pc_o == '0) && (act_o == '0));
endmodule

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en_i = 1'b0;
  logic        pgm_valid_i = 1'b0;
  logic        pgm_is_addr_i = 1'b0;
  logic [17:0] pgm_word_i = '0;
  logic        evt_init_i = 1'b0;
  logic [63:0] cond_i = '0;
  logic [9:0]  pc_o;
  logic [54:0] act_o;

  always #10 clk = ~clk;

  useq_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .run_en_i(run_en_i), .pgm_valid_i(pgm_valid_i),
    .pgm_is_addr_i(pgm_is_addr_i), .pgm_word_i(pgm_word_i),
    .evt_init_i(evt_init_i), .cond_i(cond_i), .pc_o(pc_o), .act_o(act_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [17:0] bmem [1024];
  logic [9:0]  bptr = '0;
  logic [9:0]  m_pc = '0;

  // expected strobes: walk every pair, numbering as we go
  function automatic logic [54:0] act_of(input logic [10:0] code);
    logic [54:0] v;
    int n;
    v = '0; n = 0;
    for (int a = 0; a < 10; a++)
      for (int b = a + 1; b <= 10; b++) begin
        v[n] = code[a] & code[b];
        n = n + 1;
      end
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic run, input logic pv, input logic pa,
                     input logic [17:0] w, input logic evt, input logic [63:0] c);
    logic [17:0] ins;
    logic [9:0]  npc;
    logic [54:0] nact;
    logic [1:0]  op;
    logic        hit;
    string       why, why_a;
    run_en_i = run; pgm_valid_i = pv; pgm_is_addr_i = pa; pgm_word_i = w;
    evt_init_i = evt; cond_i = c;
    ins  = bmem[m_pc];
    op   = ins[17:16];
    hit  = c[ins[15:10]];
    nact = '0;
    why_a = "R5";
    if (!run)          begin npc = 10'd0; why = "R2"; end
    else if (pv)       begin npc = 10'd0; why = "R10"; end
    else if (evt)      begin npc = 10'h020; why = "R9"; end
    else begin
      case (op)
        2'd0: begin npc = m_pc + 10'd1; why = "R4"; nact = act_of(ins[10:0]); why_a = "R4 R3"; end
        2'd1: begin npc = hit ? ins[9:0] : m_pc + 10'd1; why = "R6"; end
        2'd2: begin npc = ins[9:0]; why = "R7"; end
        default: begin npc = hit ? m_pc + 10'd1 : m_pc; why = "R8"; end
      endcase
    end
    if (pv) begin
      if (pa) bptr = w[9:0];
      else begin bmem[bptr] = w; bptr = bptr + 10'd1; end
    end
    @(posedge clk);
    @(negedge clk);
    chk(pc_o === npc, {why, " pc"}, 64'(pc_o), 64'(npc));
    chk(act_o === nact, {why_a, " strobes"}, 64'(act_o), 64'(nact));
    m_pc = npc;
  endtask

  task automatic load(input logic [9:0] a, input logic [17:0] w);
    cyc(1'b0, 1'b1, 1'b1, 18'(a), 1'b0, '0);
    cyc(1'b0, 1'b1, 1'b0, w, 1'b0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240117));
    for (int i = 0; i < 1024; i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pc_o === 10'd0, "R1 pc", 64'(pc_o), 64'd0);
    chk(act_o === '0, "R1 strobes", 64'(act_o), 64'd0);

    // R3 program load: pointer word then a run of data words
    cyc(1'b0, 1'b1, 1'b1, 18'd0, 1'b0, '0);
    cyc(1'b0, 1'b1, 1'b0, 18'h00000, 1'b0, '0); // 0: nop action
    cyc(1'b0, 1'b1, 1'b0, 18'h00003, 1'b0, '0); // 1: action bits 0,1
    cyc(1'b0, 1'b1, 1'b0, 18'h00600, 1'b0, '0); // 2: action bits 9,10
    cyc(1'b0, 1'b1, 1'b0, 18'h31400, 1'b0, '0); // 3: wait cond 5
    cyc(1'b0, 1'b1, 1'b0, 18'h10C04, 1'b0, '0); // 4: cjmp cond 3 -> self
    cyc(1'b0, 1'b1, 1'b0, 18'h00024, 1'b0, '0); // 5: action bits 2,5
    cyc(1'b0, 1'b1, 1'b0, 18'h11C01, 1'b0, '0); // 6: cjmp cond 7 -> 1
    cyc(1'b0, 1'b1, 1'b0, 18'h20002, 1'b0, '0); // 7: jmp 2
    load(10'h020, 18'h00401);                    // entry: action bits 0,10
    load(10'h021, 18'h20003);                    // jmp 3
    cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, '0);         // R2 idle

    // directed: nop, two actions, R8 wait stall, release, R6 self loop
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0);
    cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, 64'h20);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, 64'h08);
    cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, 64'h00);
    cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, 64'h80);
    // R9 event from any point
    cyc(1'b1, 1'b0, 1'b0, '0, 1'b1, '0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, '0, 1'b0, '0);

    // random conditions and events
    for (int i = 0; i < 3000; i++) begin
      logic run, evt;
      run = ($urandom % 100) != 0;
      evt = ($urandom % 40) == 0;
      cyc(run, 1'b0, 1'b0, '0, evt, {$urandom, $urandom});
    end

    // R10: rewrite address 7 while running (write wins over event)
    cyc(1'b1, 1'b1, 1'b1, 18'd7, 1'b1, '0);
    cyc(1'b1, 1'b1, 1'b0, 18'h20000, 1'b0, '0);
    for (int i = 0; i < 1500; i++) begin
      logic evt;
      evt = ($urandom % 60) == 0;
      cyc(1'b1, 1'b0, 1'b0, '0, evt, {$urandom, $urandom});
    end
    finish_run();
  end
endmodule